// File: doc/BRIEF.md
# Time-aware gate command scheduler

This block drives the transmit gates of eight priority queues of one egress port. It walks a list of gate commands kept in a small local command store. Each command is one word. The upper field is a fetch count. The low eight bits are a gate-allow mask, and bit i of the mask lets priority i transmit. A command stays in force until the link has moved as many units of data as its count says. At gigabit speed a unit is a byte. At 10/100 speeds a unit is a nibble. The block then moves on to the next command.

The store is split into two equal banks, so software can write the idle bank through a simple write port while the other bank runs. A bank-select input names the bank for the next cycle. The switch happens only on the periodic cycle-start pulse, and the active-bank output shows which bank is in use. A command whose count is zero closes the list, and its mask stays applied until the next cycle start. A single-bank mode treats the whole store as one list starting at address zero.

When either enable input is low, all eight gates are held open.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, gate_o is 8'hFF (all gates open) and act_bank_o is 0, and this holds until the first cycle_start_i pulse.
- R2: In double-bank mode (one_buf_i = 0), a cycle_start_i pulse makes act_bank_o equal bank_sel_i. On the next clock, gate_o shows the mask of word 0 of that bank. A word is {count, mask[7:0]}. Write address bit PW-1 selects the bank, and the low bits give the index within the bank.
- R3: A change of bank_sel_i between cycle_start_i pulses has no effect on act_bank_o or gate_o until the next pulse.
- R4: With speed_gig_i = 1, the count decrements on byte_tick_i only, and nib_tick_i is ignored.
- R5: With speed_gig_i = 0, the count decrements on nib_tick_i only, and byte_tick_i is ignored.
- R6: A nonzero count below 16 is treated as 16.
- R7: A command with count 0 ends the list. Its mask stays on gate_o, whatever ticks arrive, until the next cycle_start_i.
- R8: If the last word of the running list has a nonzero count and its count expires, its mask is held until the next cycle_start_i.
- R9: While glb_en_i or port_en_i is low, gate_o is 8'hFF. When both are high again, the running mask returns.
- R10: If one_buf_i = 1 at the cycle_start_i pulse, the list starts at address 0 and may run through all 2*CMD_DEPTH words, and act_bank_o is 0.
- R11: A command with effective count N applies its mask for exactly N selected ticks. On the clock after the Nth tick, the next word's mask appears, so an interval can be split over several words that carry the same mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global schedule enable |
| port_en_i | input | 1 | Port schedule enable |
| speed_gig_i | input | 1 | 1: count bytes, 0: count nibbles |
| byte_tick_i | input | 1 | One pulse per byte on the wire |
| nib_tick_i | input | 1 | One pulse per nibble on the wire |
| cycle_start_i | input | 1 | Periodic cycle-start pulse |
| bank_sel_i | input | 1 | Bank to use from the next cycle |
| one_buf_i | input | 1 | Single-bank mode |
| wr_en_i | input | 1 | Command store write strobe |
| wr_addr_i | input | PW | Command word address, MSB is the bank |
| wr_data_i | input | CNT_W+8 | Command word {count, mask} |
| gate_o | output | 8 | Gate-allow mask, bit i for priority i |
| act_bank_o | output | 1 | Bank in use |

## Verification
The hardest case to reach from the ports is a list that runs off the end of its bank without a terminator, and then keeps holding its last mask. The bench fills one bank entirely with nonzero counts. It switches to that bank by changing bank_sel_i mid-cycle and confirms that nothing moves before the pulse. It then pushes more than enough nibble ticks to pass the last word. Single-bank mode is reached by rewriting the first bank's terminator so that the walk visibly crosses into the second bank.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int unsigned NUM_GATES = 8;
  localparam int unsigned MIN_FETCH = 16;
  typedef logic [NUM_GATES-1:0] gate_t;
endpackage

// File: rtl/tas_cmd_ram.sv
module tas_cmd_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 20,
  localparam int unsigned PW   = $clog2(2*DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [CW-1:0] rd_data_o
);
  logic [CW-1:0] mem_q [2*DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2*DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tas_tick_sel.sv
module tas_tick_sel (
  input  logic speed_gig_i,
  input  logic byte_tick_i,
  input  logic nib_tick_i,
  output logic tick_o
);
  assign tick_o = speed_gig_i ? byte_tick_i : nib_tick_i;
endmodule

// File: rtl/tas_seq.sv
module tas_seq
  import tas_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 12,
  localparam int unsigned PW   = $clog2(2*DEPTH),
  localparam int unsigned CW   = CNT_W + NUM_GATES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cycle_start_i,
  input  logic          tick_i,
  input  logic          bank_sel_i,
  input  logic          one_buf_i,
  output logic [PW-1:0] rd_addr_o,
  input  logic [CW-1:0] rd_data_i,
  output gate_t         mask_o,
  output logic          act_bank_o
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_FETCH);

  logic [PW-1:0]    ptr_q, base, last;
  logic [CNT_W-1:0] cnt_q, rd_cnt, rd_eff;
  gate_t            mask_q, rd_mask;
  logic             done_q, bank_q, one_q;

  assign rd_cnt  = rd_data_i[CW-1:NUM_GATES];
  assign rd_mask = rd_data_i[NUM_GATES-1:0];
  // short nonzero intervals are stretched to the minimum fetch
  assign rd_eff  = (rd_cnt != '0 && rd_cnt < MIN_CNT) ? MIN_CNT : rd_cnt;

  assign base      = one_buf_i ? '0 : {bank_sel_i, {(PW-1){1'b0}}};
  assign last      = one_q ? '1 : {bank_q, {(PW-1){1'b1}}};
  assign rd_addr_o = cycle_start_i ? base : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      mask_q <= '1;
      done_q <= 1'b1;
      bank_q <= 1'b0;
      one_q  <= 1'b0;
    end else if (cycle_start_i) begin
      bank_q <= one_buf_i ? 1'b0 : bank_sel_i;
      one_q  <= one_buf_i;
      ptr_q  <= base;
      mask_q <= rd_mask;
      cnt_q  <= rd_eff;
      done_q <= (rd_cnt == '0);
    end else if (tick_i && !done_q) begin
      if (cnt_q > 1) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (ptr_q == last) begin
        done_q <= 1'b1;
      end else begin
        ptr_q  <= ptr_q + 1'b1;
        mask_q <= rd_mask;
        cnt_q  <= rd_eff;
        done_q <= (rd_cnt == '0);
      end
    end
  end

  assign mask_o     = mask_q;
  assign act_bank_o = bank_q;
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned CNT_W     = 12,
  localparam int unsigned PW       = $clog2(2*CMD_DEPTH),
  localparam int unsigned CW       = CNT_W + NUM_GATES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 glb_en_i,
  input  logic                 port_en_i,
  input  logic                 speed_gig_i,
  input  logic                 byte_tick_i,
  input  logic                 nib_tick_i,
  input  logic                 cycle_start_i,
  input  logic                 bank_sel_i,
  input  logic                 one_buf_i,
  input  logic                 wr_en_i,
  input  logic [PW-1:0]        wr_addr_i,
  input  logic [CW-1:0]        wr_data_i,
  output logic [NUM_GATES-1:0] gate_o,
  output logic                 act_bank_o
);
  logic [PW-1:0] rd_addr;
  logic [CW-1:0] rd_data;
  logic          tick;
  gate_t         mask;

  tas_cmd_ram #(.DEPTH(CMD_DEPTH), .CW(CW)) u_ram (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  tas_tick_sel u_tick (
    .speed_gig_i, .byte_tick_i, .nib_tick_i, .tick_o(tick)
  );

  tas_seq #(.DEPTH(CMD_DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .cycle_start_i, .tick_i(tick), .bank_sel_i, .one_buf_i,
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .mask_o(mask),
    .act_bank_o
  );

  assign gate_o = (glb_en_i && port_en_i) ? mask : '1;
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       glb_en_i,
  input logic       port_en_i,
  input logic       speed_gig_i,
  input logic       byte_tick_i,
  input logic       nib_tick_i,
  input logic       cycle_start_i,
  input logic       bank_sel_i,
  input logic       one_buf_i,
  input logic [7:0] gate_o,
  input logic       act_bank_o
);
  logic sel_tick, en;
  assign sel_tick = speed_gig_i ? byte_tick_i : nib_tick_i;
  assign en       = glb_en_i && port_en_i;

  // R9
  p_open_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> $countones(gate_o) == 8);

  // R3
  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_start_i |=> $stable(act_bank_o));

  // R2
  p_bank_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && !one_buf_i) |=> act_bank_o == $past(bank_sel_i));

  // R10
  p_one_buf_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && one_buf_i) |=> !act_bank_o);

  // R4, R5: no selected tick and no pulse leaves the mask alone
  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !cycle_start_i && !sel_tick) |=> (!en || $stable(gate_o)));
endmodule

bind tas_gate_sched tas_gate_sched_chk u_chk (.*);

// File: tb/tas_gate_sched_test.sv
module tas_gate_sched_test;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned CNT_W = 10;
  localparam int unsigned PW    = $clog2(2*DEPTH);
  localparam int unsigned CW    = CNT_W + 8;

  logic clk = 0, rst_n = 0;
  logic glb_en = 1, port_en = 1, speed_gig = 1, byte_t = 0, nib_t = 0;
  logic cs = 0, bank_sel = 0, one_buf = 0, wr_en = 0;
  logic [PW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [7:0] gate;
  logic       bank;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tas_gate_sched #(.CMD_DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .port_en_i(port_en),
    .speed_gig_i(speed_gig), .byte_tick_i(byte_t), .nib_tick_i(nib_t),
    .cycle_start_i(cs), .bank_sel_i(bank_sel), .one_buf_i(one_buf),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .gate_o(gate), .act_bank_o(bank)
  );

  // {cs, byte, nib, reps[7:0], exp_gate[7:0]}, gigabit, bank 0
  localparam int VN = 8;
  localparam logic [18:0] VEC [VN] = '{
    {3'b100, 8'd1,  8'h01},  // R2 first word
    {3'b010, 8'd19, 8'h01},  // R11 still first
    {3'b010, 8'd1,  8'h02},  // R11 advance after 20
    {3'b001, 8'd20, 8'h02},  // R4 nibble ignored
    {3'b010, 8'd15, 8'h02},  // R6 count 5 -> 16
    {3'b010, 8'd1,  8'hFC},  // R6 / R7 terminator
    {3'b010, 8'd40, 8'hFC},  // R7 held
    {3'b000, 8'd5,  8'hFC}   // R7 idle
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int c, input logic [7:0] m);
    @(negedge clk);
    wr_en = 1; wr_addr = PW'(a); wr_data = {CNT_W'(c), m};
    @(negedge clk);
    wr_en = 0;
  endtask

  // drive at negedge, run n cycles, leave the bench at the next negedge
  task automatic run(input logic c, input logic b, input logic n, input int reps);
    for (int i = 0; i < reps; i++) begin
      @(negedge clk);
      cs = c; byte_t = b; nib_t = n;
    end
    @(negedge clk);
    cs = 0; byte_t = 0; nib_t = 0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gate, 8'hFF, "R1 gate");
    chk({7'd0, bank}, 8'h00, "R1 bank");

    wr(0, 20, 8'h01); wr(1, 5, 8'h02); wr(2, 0, 8'hFC); wr(3, 16, 8'hAA);
    wr(4, 16, 8'h10); wr(5, 16, 8'h20); wr(6, 16, 8'h40); wr(7, 16, 8'h80);
    run(0, 1, 0, 30);
    chk(gate, 8'hFF, "R1 no pulse yet");

    for (int v = 0; v < VN; v++) begin
      run(VEC[v][18], VEC[v][17], VEC[v][16], int'(VEC[v][15:8]));
      chk(gate, VEC[v][7:0], $sformatf("vector %0d", v));
    end

    // R3 select bank 1 mid-cycle
    bank_sel = 1;
    run(0, 1, 0, 10);
    chk({7'd0, bank}, 8'h00, "R3 bank");
    chk(gate, 8'hFC, "R3 gate");
    run(1, 0, 0, 1);
    chk({7'd0, bank}, 8'h01, "R2 bank");
    chk(gate, 8'h10, "R2 gate");

    // R5 nibble mode
    speed_gig = 0;
    run(0, 0, 1, 16);
    chk(gate, 8'h20, "R5 nibble advance");
    run(0, 1, 0, 30);
    chk(gate, 8'h20, "R5 byte ignored");

    // R8 run off the end of bank 1
    run(0, 0, 1, 32);
    chk(gate, 8'h80, "R8 last word");
    run(0, 0, 1, 50);
    chk(gate, 8'h80, "R8 held");

    // R9 enables
    glb_en = 0; #1;
    chk(gate, 8'hFF, "R9 global off");
    glb_en = 1; #1;
    chk(gate, 8'h80, "R9 restored");
    port_en = 0; #1;
    chk(gate, 8'hFF, "R9 port off");
    port_en = 1;

    // R10 single bank walks across the bank boundary
    wr(2, 16, 8'h04); wr(3, 16, 8'h08);
    speed_gig = 1; one_buf = 1;
    run(1, 0, 0, 1);
    chk({7'd0, bank}, 8'h00, "R10 bank");
    chk(gate, 8'h01, "R10 start");
    run(0, 1, 0, 20 + 16 + 16);
    chk(gate, 8'h08, "R10 word 3");
    run(0, 1, 0, 16);
    chk(gate, 8'h10, "R10 crossed");
    chk({7'd0, bank}, 8'h00, "R10 bank held");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule